// File: doc/BRIEF.md
# Decoy Sweep Arming Controller

This controller sits beside the instruction decoder. It decides which decoded instructions should have a decoy sweep injected ahead of them. The sweep is the extra micro-op sequence that touches every cache line of a sensitive region. That way, an access that depends on a secret leaves no distinct footprint in the cache.

Trusted software programs two address windows through a small register-write port: a code window and a data window. It also programs a watchdog period and a mode word. Writing any window bound arms the controller. At that moment the windows and the mode are copied into shadow registers, and all decisions use the shadow copies.

While the controller is armed, a decoded memory or branch instruction qualifies in one of two ways. In address mode, it qualifies when its PC falls inside the shadow code window. In taint mode, it qualifies when the decoder flags it as tainted. A qualifying instruction raises a one-cycle injection request, together with the sweep bounds. The controller then disarms and starts the watchdog. When the watchdog expires, the controller re-arms and takes a fresh copy of the programmed settings.

Generating the sweep micro-ops is left to a downstream sequencer.

Top module: `decoy_arm_ctrl`

## Requirements
- R1: A synchronous reset leaves the controller disarmed. It also clears every request output and every sweep bound to zero, and sets the mode word to address mode with both sides enabled (value 3'b110).
- R2: A write with select 0 (code low), 1 (code high), 2 (data low) or 3 (data high) arms the controller on the next cycle. The same edge copies all four bounds and the mode into the shadow registers, and the sweep bound outputs show those shadow copies.
- R3: A write with select 4 (watchdog period), 5 (mode) or 6/7 (unused) never arms the controller.
- R4: In address mode, an armed controller raises the request one cycle after a valid instruction whose load/store or branch flag is set and whose PC satisfies code-low <= PC < code-high. A PC equal to the high bound or below the low bound does not qualify.
- R5: No request follows an instruction that is invalid, has neither the load/store nor the branch flag, arrives while disarmed, or meets an empty window (high <= low).
- R6: The request is a single-cycle pulse, and the controller is disarmed from the same edge, so each arming services at most one instruction.
- R7: With a period P > 0, the controller re-arms exactly P cycles after the disarming edge. The period value used is the one in the period register at that edge.
- R8: A period of 0 disables the watchdog, and the controller stays disarmed until a window write.
- R9: A window write re-arms a disarmed controller at once and cancels any running watchdog count. A write in the same cycle as a qualifying instruction wins: no request is raised.
- R10: When mode bit 0 (taint select) is set in the shadow mode, the taint flag replaces the PC window test. A load/store or branch still has to be present.
- R11: The code-side request follows the request when mode bit 1 is set, and the data-side request follows it when mode bit 2 is set. Both bits, and bit 0, come from the shadow mode captured at arming, so a mode write takes effect only at the next arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select (0..3 window bounds, 4 period, 5 mode) |
| cfg_wr_data | input | AW | Write data |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_pc | input | AW | PC of the decoded instruction |
| dec_is_mem | input | 1 | Instruction contains a load or store |
| dec_is_branch | input | 1 | Instruction contains a branch |
| dec_taint | input | 1 | Dynamic taint flag for the instruction |
| inj_req | output | 1 | Inject-decoy request pulse |
| inj_iside | output | 1 | Request targets the code window |
| inj_dside | output | 1 | Request targets the data window |
| armed | output | 1 | Controller armed |
| sweep_i_lo | output | AW | Shadow code window low bound |
| sweep_i_hi | output | AW | Shadow code window high bound |
| sweep_d_lo | output | AW | Shadow data window low bound |
| sweep_d_hi | output | AW | Shadow data window high bound |

## Verification
The hardest situation to reach is the interplay between the watchdog and a window write. A write has to land while a count is running and be seen to cancel it, and a write has to coincide exactly with a qualifying instruction.

The stimulus table reaches these cases in a fixed order. It programs a short period, lets one request disarm the controller, and counts the idle cycles up to re-arming. It then changes the mode while armed, to show that the change is held back until the next arming. A following window write re-arms the controller while a count is running. The last row drives a write and a qualifying instruction in the same cycle. Directed tests then cover a zero period and a reset part-way through a run.

// File: rtl/decoy_pkg.sv
package decoy_pkg;

  // register select codes on the write port
  typedef enum logic [2:0] {
    SEL_I_LO   = 3'd0,
    SEL_I_HI   = 3'd1,
    SEL_D_LO   = 3'd2,
    SEL_D_HI   = 3'd3,
    SEL_PERIOD = 3'd4,
    SEL_MODE   = 3'd5
  } cfg_sel_e;

  // number of windows: index 0 code side, index 1 data side
  localparam int NRANGE = 2;

  // mode word layout
  localparam int MODE_W   = 3;
  localparam int MB_TAINT = 0;
  localparam int MB_ISIDE = 1;
  localparam int MB_DSIDE = 2;
  localparam logic [MODE_W-1:0] MODE_RST = 3'b110;

endpackage

// File: rtl/decoy_cfg_regs.sv
module decoy_cfg_regs
  import decoy_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int DEF_PERIOD = 1000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_sel,
  input  logic [AW-1:0]              wr_data,
  output logic [NRANGE-1:0][AW-1:0]  lo_nxt,
  output logic [NRANGE-1:0][AW-1:0]  hi_nxt,
  output logic [MODE_W-1:0]          mode_nxt,
  output logic [CW-1:0]              period,
  output logic                       range_wr
);

  logic [NRANGE-1:0][AW-1:0] lo_q;
  logic [NRANGE-1:0][AW-1:0] hi_q;
  logic [MODE_W-1:0]         mode_q;
  logic [CW-1:0]             period_q;

  // one low/high pair per window; next value merges the write in
  for (genvar r = 0; r < NRANGE; r++) begin : g_win
    logic wr_lo, wr_hi;
    assign wr_lo     = wr_en && (wr_sel == 3'(2*r));
    assign wr_hi     = wr_en && (wr_sel == 3'(2*r+1));
    assign lo_nxt[r] = wr_lo ? wr_data : lo_q[r];
    assign hi_nxt[r] = wr_hi ? wr_data : hi_q[r];

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[r] <= '0;
        hi_q[r] <= '0;
      end else begin
        lo_q[r] <= lo_nxt[r];
        hi_q[r] <= hi_nxt[r];
      end
    end
  end

  assign mode_nxt = (wr_en && wr_sel == SEL_MODE) ? wr_data[MODE_W-1:0] : mode_q;
  assign range_wr = wr_en && (wr_sel <= SEL_D_HI);
  assign period   = period_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RST;
      period_q <= CW'(DEF_PERIOD);
    end else begin
      mode_q <= mode_nxt;
      if (wr_en && wr_sel == SEL_PERIOD) period_q <= wr_data[CW-1:0];
    end
  end

endmodule

// File: rtl/decoy_range_match.sv
module decoy_range_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          hit
);

  // half-open window; hi <= lo can never satisfy both bounds
  assign hit = (addr >= lo) && (addr < hi);

endmodule

// File: rtl/decoy_wdog.sv
module decoy_wdog #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cancel,
  input  logic [CW-1:0] period,
  output logic          expire
);

  logic [CW-1:0] cnt;
  logic          run;

  assign expire = run && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= (period != '0);
      cnt <= period;
    end else if (run) begin
      if (cnt == CW'(1)) run <= 1'b0;
      cnt <= cnt - CW'(1);
    end
  end

endmodule

// File: rtl/decoy_arm_ctrl.sv
module decoy_arm_ctrl
  import decoy_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int DEF_PERIOD = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr_en,
  input  logic [2:0]    cfg_wr_sel,
  input  logic [AW-1:0] cfg_wr_data,
  input  logic          dec_valid,
  input  logic [AW-1:0] dec_pc,
  input  logic          dec_is_mem,
  input  logic          dec_is_branch,
  input  logic          dec_taint,
  output logic          inj_req,
  output logic          inj_iside,
  output logic          inj_dside,
  output logic          armed,
  output logic [AW-1:0] sweep_i_lo,
  output logic [AW-1:0] sweep_i_hi,
  output logic [AW-1:0] sweep_d_lo,
  output logic [AW-1:0] sweep_d_hi
);

  logic [NRANGE-1:0][AW-1:0] lo_nxt, hi_nxt;
  logic [NRANGE-1:0][AW-1:0] sh_lo, sh_hi;
  logic [MODE_W-1:0]         mode_nxt, sh_mode;
  logic [CW-1:0]             period;
  logic                      range_wr, wd_expire, arm_load;
  logic                      pc_hit, sel_ok, qualify;
  logic                      armed_q, inj_q, inj_i_q, inj_d_q;

  decoy_cfg_regs #(.AW(AW), .CW(CW), .DEF_PERIOD(DEF_PERIOD)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
    .lo_nxt(lo_nxt), .hi_nxt(hi_nxt), .mode_nxt(mode_nxt),
    .period(period), .range_wr(range_wr)
  );

  decoy_wdog #(.CW(CW)) u_wdog (
    .clk(clk), .rst(rst),
    .start(qualify), .cancel(range_wr), .period(period),
    .expire(wd_expire)
  );

  decoy_range_match #(.AW(AW)) u_pc_match (
    .addr(dec_pc), .lo(sh_lo[0]), .hi(sh_hi[0]), .hit(pc_hit)
  );

  assign arm_load = range_wr || wd_expire;

  // shadow copies of the windows, refreshed on every arming
  for (genvar r = 0; r < NRANGE; r++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_lo[r] <= '0;
        sh_hi[r] <= '0;
      end else if (arm_load) begin
        sh_lo[r] <= lo_nxt[r];
        sh_hi[r] <= hi_nxt[r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           sh_mode <= MODE_RST;
    else if (arm_load) sh_mode <= mode_nxt;
  end

  assign sel_ok  = sh_mode[MB_TAINT] ? dec_taint : pc_hit;
  // a window write in the same cycle takes priority over a request
  assign qualify = armed_q && dec_valid && (dec_is_mem || dec_is_branch)
                   && sel_ok && !range_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      inj_q   <= 1'b0;
      inj_i_q <= 1'b0;
      inj_d_q <= 1'b0;
    end else begin
      if (arm_load)     armed_q <= 1'b1;
      else if (qualify) armed_q <= 1'b0;
      inj_q   <= qualify;
      inj_i_q <= qualify && sh_mode[MB_ISIDE];
      inj_d_q <= qualify && sh_mode[MB_DSIDE];
    end
  end

  assign armed      = armed_q;
  assign inj_req    = inj_q;
  assign inj_iside  = inj_i_q;
  assign inj_dside  = inj_d_q;
  assign sweep_i_lo = sh_lo[0];
  assign sweep_i_hi = sh_hi[0];
  assign sweep_d_lo = sh_lo[1];
  assign sweep_d_hi = sh_hi[1];

endmodule

// File: rtl/decoy_arm_ctrl_chk.sv
module decoy_arm_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_wr_en,
  input logic [2:0]    cfg_wr_sel,
  input logic          dec_valid,
  input logic          dec_is_mem,
  input logic          dec_is_branch,
  input logic          inj_req,
  input logic          inj_iside,
  input logic          inj_dside,
  input logic          armed,
  input logic [AW-1:0] sweep_i_lo,
  input logic [AW-1:0] sweep_i_hi,
  input logic [AW-1:0] sweep_d_lo,
  input logic [AW-1:0] sweep_d_hi,
  input logic          range_wr,
  input logic          wd_expire
);

  logic warm;
  always_ff @(posedge clk) warm <= !rst;

  logic win_wr;
  assign win_wr = cfg_wr_en && (cfg_wr_sel <= 3'd3);

  p_arm_on_write_r2: assert property (@(posedge clk) disable iff (rst || !warm)
    win_wr |=> armed);

  p_sweep_hold_r2: assert property (@(posedge clk) disable iff (rst || !warm)
    !$past(range_wr || wd_expire) |->
      ($stable(sweep_i_lo) && $stable(sweep_i_hi) &&
       $stable(sweep_d_lo) && $stable(sweep_d_hi)));

  p_arm_source_r3: assert property (@(posedge clk) disable iff (rst || !warm)
    $rose(armed) |-> $past(range_wr || wd_expire));

  p_inj_needs_armed_r5: assert property (@(posedge clk) disable iff (rst || !warm)
    inj_req |-> $past(armed && dec_valid && (dec_is_mem || dec_is_branch)));

  p_one_shot_r6: assert property (@(posedge clk) disable iff (rst || !warm)
    inj_req |-> !armed);

  p_write_blocks_r9: assert property (@(posedge clk) disable iff (rst || !warm)
    win_wr |=> !inj_req);

  p_side_subset_r11: assert property (@(posedge clk) disable iff (rst || !warm)
    (inj_iside || inj_dside) |-> inj_req);

endmodule

bind decoy_arm_ctrl decoy_arm_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
  .dec_valid(dec_valid), .dec_is_mem(dec_is_mem), .dec_is_branch(dec_is_branch),
  .inj_req(inj_req), .inj_iside(inj_iside), .inj_dside(inj_dside), .armed(armed),
  .sweep_i_lo(sweep_i_lo), .sweep_i_hi(sweep_i_hi),
  .sweep_d_lo(sweep_d_lo), .sweep_d_hi(sweep_d_hi),
  .range_wr(range_wr), .wd_expire(wd_expire)
);

// File: tb/decoy_arm_ctrl_bench.sv
module decoy_arm_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int NROW = 20;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_wr_en;
  logic [2:0]    cfg_wr_sel;
  logic [AW-1:0] cfg_wr_data;
  logic          dec_valid, dec_is_mem, dec_is_branch, dec_taint;
  logic [AW-1:0] dec_pc;
  logic          inj_req, inj_iside, inj_dside, armed;
  logic [AW-1:0] sweep_i_lo, sweep_i_hi, sweep_d_lo, sweep_d_hi;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decoy_arm_ctrl #(.AW(AW), .CW(CW), .DEF_PERIOD(100)) u_decoy_arm_ctrl (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_is_mem(dec_is_mem),
    .dec_is_branch(dec_is_branch), .dec_taint(dec_taint),
    .inj_req(inj_req), .inj_iside(inj_iside), .inj_dside(inj_dside), .armed(armed),
    .sweep_i_lo(sweep_i_lo), .sweep_i_hi(sweep_i_hi),
    .sweep_d_lo(sweep_d_lo), .sweep_d_hi(sweep_d_hi)
  );

  // row: req(4) wr(1) sel(3) data(16) v(1) mem(1) br(1) taint(1) pc(16)
  //      exp inj(1) exp iside(1) exp dside(1) exp armed(1)   = 48 bits
  localparam logic [47:0] TBL [NROW] = '{
    {4'd3,  1'b1,3'd4,16'h0003, 4'b0000,16'h0000, 4'b0000}, // R3 period write does not arm
    {4'd2,  1'b1,3'd0,16'h0100, 4'b0000,16'h0000, 4'b0001}, // R2 code low write arms
    {4'd5,  1'b0,3'd0,16'h0000, 4'b1100,16'h0120, 4'b0001}, // R5 empty window (hi=0)
    {4'd2,  1'b1,3'd1,16'h0200, 4'b0000,16'h0000, 4'b0001}, // R2 code high write
    {4'd5,  1'b0,3'd0,16'h0000, 4'b1000,16'h0150, 4'b0001}, // R5 no mem/branch flag
    {4'd4,  1'b0,3'd0,16'h0000, 4'b1100,16'h0200, 4'b0001}, // R4 hi bound exclusive
    {4'd4,  1'b0,3'd0,16'h0000, 4'b1100,16'h00FF, 4'b0001}, // R4 below low bound
    {4'd4,  1'b0,3'd0,16'h0000, 4'b1010,16'h0100, 4'b1110}, // R4 branch at low bound
    {4'd6,  1'b0,3'd0,16'h0000, 4'b1100,16'h0150, 4'b0000}, // R6 disarmed after one
    {4'd7,  1'b0,3'd0,16'h0000, 4'b0000,16'h0000, 4'b0000}, // R7 still counting
    {4'd7,  1'b0,3'd0,16'h0000, 4'b0000,16'h0000, 4'b0001}, // R7 re-armed after 3
    {4'd11, 1'b1,3'd5,16'h0003, 4'b0000,16'h0000, 4'b0001}, // R11 mode write held back
    {4'd11, 1'b0,3'd0,16'h0000, 4'b1100,16'h0150, 4'b1110}, // R11 old mode still used
    {4'd9,  1'b1,3'd2,16'h0800, 4'b0000,16'h0000, 4'b0001}, // R9 write re-arms now
    {4'd10, 1'b0,3'd0,16'h0000, 4'b1100,16'h0150, 4'b0001}, // R10 untainted in range
    {4'd10, 1'b0,3'd0,16'h0000, 4'b1101,16'h0900, 4'b1100}, // R10 tainted, I-side only
    {4'd7,  1'b0,3'd0,16'h0000, 4'b0000,16'h0000, 4'b0000}, // R7
    {4'd7,  1'b0,3'd0,16'h0000, 4'b0000,16'h0000, 4'b0000}, // R7
    {4'd7,  1'b0,3'd0,16'h0000, 4'b0000,16'h0000, 4'b0001}, // R7 re-arm
    {4'd9,  1'b1,3'd3,16'h0900, 4'b1101,16'h0850, 4'b0001}  // R9 write beats request
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_wr_en = 0; cfg_wr_sel = '0; cfg_wr_data = '0;
    dec_valid = 0; dec_pc = '0; dec_is_mem = 0; dec_is_branch = 0; dec_taint = 0;
  endtask

  task automatic step_wr(input logic [2:0] sel, input logic [AW-1:0] d);
    idle_inputs();
    cfg_wr_en = 1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic step_dec(input logic [AW-1:0] pc);
    idle_inputs();
    dec_valid = 1; dec_is_mem = 1; dec_pc = pc;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic step_idle();
    idle_inputs();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 armed", armed, 0);
    check("R1 inj", {inj_req, inj_iside, inj_dside}, 0);
    check("R1 sweep", {sweep_i_lo, sweep_i_hi, sweep_d_lo, sweep_d_hi}, 0);

    for (int i = 0; i < NROW; i++) begin
      logic [47:0] row;
      row = TBL[i];
      cfg_wr_en = row[43]; cfg_wr_sel = row[42:40]; cfg_wr_data = row[39:24];
      dec_valid = row[23]; dec_is_mem = row[22]; dec_is_branch = row[21];
      dec_taint = row[20]; dec_pc = row[19:4];
      @(negedge clk);
      check($sformatf("R%0d row %0d outputs", row[47:44], i),
            {inj_req, inj_iside, inj_dside, armed}, row[3:0]);
    end
    idle_inputs();

    // R2 sweep bounds from shadow copies
    check("R2 code lo", sweep_i_lo, 16'h0100);
    check("R2 code hi", sweep_i_hi, 16'h0200);
    check("R2 data lo", sweep_d_lo, 16'h0800);
    check("R2 data hi", sweep_d_hi, 16'h0900);

    // R8 zero period: no re-arm
    step_wr(3'd4, 16'h0000);
    step_wr(3'd5, 16'h0006);
    step_wr(3'd0, 16'h0100);       // re-copies mode 6 (address mode)
    step_dec(16'h0150);
    check("R4 request in address mode", inj_req, 1);
    repeat (20) step_idle();
    check("R8 stays disarmed", armed, 0);
    // R3 unused select ignored
    step_wr(3'd6, 16'h0100);
    check("R3 unused select", armed, 0);
    step_wr(3'd5, 16'h0006);
    check("R3 mode write", armed, 0);
    // R9 write re-arms a disarmed controller
    step_wr(3'd1, 16'h0300);
    check("R9 re-armed by write", armed, 1);
    check("R2 new code hi", sweep_i_hi, 16'h0300);
    step_dec(16'h0050);
    check("R5 below window", inj_req, 0);

    // R1 reset in mid-run
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    check("R1 armed after reset", armed, 0);
    check("R1 sweep after reset", {sweep_i_lo, sweep_i_hi}, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule